// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block takes a set of interrupt sources and, for every CPU interface, works out which source should be offered to that CPU. Each source has one 8-bit priority value that all CPUs share. Each CPU has its own enable bit and pending bit for every source. Each CPU also has its own interface enable, a priority mask and a running priority. A lower priority value means a more urgent interrupt. One distributor-wide enable gates all CPUs.

For each CPU the block reports the ID of the winning source, or the spurious ID 1023 when nothing may be reported. It also drives a request line toward that CPU. Two thresholds gate the winner, one after the other. The priority mask decides whether the winner is reported at all. The running priority then decides whether a reported winner also raises the request line.

Register access, acknowledge and end-of-interrupt handling, and edge or level capture are all outside this block. Their results arrive as plain inputs. Each CPU has a combinational comparator tree followed by one output register stage.

Top module: `hpsel_top`

## Requirements
- R1: Among qualifying sources, the one with the numerically smallest priority wins. When priorities are equal, the smallest source ID wins. A source displaces the current best only when its value is strictly smaller.
- R2: Source i qualifies for CPU c only when both `src_en[c*N_SRC+i]` and `src_pend[c*N_SRC+i]` are 1. The priority of source i is `src_prio[i*8 +: 8]`.
- R3: When no source qualifies for CPU c, `pend_id[c*10 +: 10]` reads 1023. Otherwise it reads an ID below N_SRC.
- R4: The winner is reported on `pend_id` only when its priority is strictly below `prio_mask[c*8 +: 8]`. Otherwise 1023 is reported.
- R5: `irq_req[c]` is 1 only when a winner is reported and its priority is strictly below `run_prio[c*9 +: 9]`. This field is 9 bits wide, and the value 0x100 means that nothing is running.
- R6: While `dist_en` is 0 or `cpu_en[c]` is 0, CPU c sees `irq_req[c]` = 0 and `pend_id` = 1023.
- R7: Both outputs are registered. Their values after a rising clock edge are computed from the inputs sampled at that edge. Before that edge the outputs keep their previous values.
- R8: While `rst_n` is 0, every CPU shows `irq_req` = 0 and `pend_id` = 1023.
- R9: Each CPU's selection and gating depend only on that CPU's enable, pending, mask, running-priority and interface-enable inputs, together with the shared priorities and `dist_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Distributor-wide enable |
| cpu_en | input | N_CPU | Per-CPU interface enable |
| src_en | input | N_CPU*N_SRC | Per-CPU source enables, bit c*N_SRC+i |
| src_pend | input | N_CPU*N_SRC | Per-CPU pending bits, bit c*N_SRC+i |
| src_prio | input | N_SRC*8 | Shared source priorities, 8 bits per source |
| prio_mask | input | N_CPU*8 | Per-CPU priority mask |
| run_prio | input | N_CPU*9 | Per-CPU running priority, 0x100 = idle |
| pend_id | output | N_CPU*10 | Per-CPU reported pending ID, 1023 = spurious |
| irq_req | output | N_CPU | Per-CPU interrupt request |

## Verification
The bench builds the block with N_SRC = 5 and N_CPU = 2. Five sources do not fill a power of two, so the padded leaves of the tree take part in every selection. A win by the highest real ID therefore shows that padding never beats a genuine source. Two CPUs are enough to drive different enables, masks and running priorities at the same time and to see that the CPUs stay independent. With only two CPUs, both outputs are small enough to compare in full at every check.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
  localparam int PRIO_W = 8;
  localparam int RANK_W = PRIO_W + 1;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0]   ID_NONE   = 10'd1023;
  localparam logic [RANK_W-1:0] RANK_IDLE = 9'h100;

  // Rank of one leaf: its priority if it qualifies, else the idle rank.
  function automatic logic [RANK_W-1:0] leaf_rank(input logic ok,
                                                  input logic [PRIO_W-1:0] p);
    return ok ? {1'b0, p} : RANK_IDLE;
  endfunction

  // The higher-ID side wins only on a strictly smaller rank.
  function automatic logic take_right(input logic [RANK_W-1:0] lo_side,
                                      input logic [RANK_W-1:0] hi_side);
    return hi_side < lo_side;
  endfunction

  // Strict threshold test used by both mask and running-priority gates.
  function automatic logic under(input logic [RANK_W-1:0] rank,
                                 input logic [RANK_W-1:0] limit);
    return rank < limit;
  endfunction
endpackage

// File: rtl/hpsel_tree.sv
module hpsel_tree
  import hpsel_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0]        qual,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  output logic [RANK_W-1:0]       best_rank,
  output logic [ID_W-1:0]         best_id
);
  localparam int LVL    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES;

  logic [LEAVES-1:0]        qual_pad;
  logic [LEAVES*PRIO_W-1:0] prio_pad;
  logic [RANK_W-1:0]        rank_n [1:NODES-1];
  logic [ID_W-1:0]          id_n   [1:NODES-1];

  assign qual_pad = LEAVES'(qual);
  assign prio_pad = (LEAVES*PRIO_W)'(prio);

  // Heap-ordered tournament: node k has children 2k (lower IDs) and 2k+1.
  always_comb begin
    for (int i = 0; i < LEAVES; i++) begin
      rank_n[LEAVES+i] = leaf_rank(qual_pad[i], prio_pad[i*PRIO_W +: PRIO_W]);
      id_n[LEAVES+i]   = ID_W'(i);
    end
    for (int k = LEAVES - 1; k >= 1; k--) begin
      if (take_right(rank_n[2*k], rank_n[2*k+1])) begin
        rank_n[k] = rank_n[2*k+1];
        id_n[k]   = id_n[2*k+1];
      end else begin
        rank_n[k] = rank_n[2*k];
        id_n[k]   = id_n[2*k];
      end
    end
  end

  assign best_rank = rank_n[1];
  assign best_id   = (rank_n[1] == RANK_IDLE) ? ID_NONE : id_n[1];
endmodule

// File: rtl/hpsel_gate.sv
module hpsel_gate
  import hpsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_on,
  input  logic [RANK_W-1:0] best_rank,
  input  logic [ID_W-1:0]   best_id,
  input  logic [PRIO_W-1:0] mask,
  input  logic [RANK_W-1:0] run,
  output logic [ID_W-1:0]   pend_id,
  output logic              irq
);
  logic shown;
  logic raise;

  assign shown = cpu_on && under(best_rank, {1'b0, mask});
  assign raise = shown && under(best_rank, run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id <= ID_NONE;
      irq     <= 1'b0;
    end else begin
      pend_id <= shown ? best_id : ID_NONE;
      irq     <= raise;
    end
  end
endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
  import hpsel_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dist_en,
  input  logic [N_CPU-1:0]        cpu_en,
  input  logic [N_CPU*N_SRC-1:0]  src_en,
  input  logic [N_CPU*N_SRC-1:0]  src_pend,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [N_CPU*PRIO_W-1:0] prio_mask,
  input  logic [N_CPU*RANK_W-1:0] run_prio,
  output logic [N_CPU*ID_W-1:0]   pend_id,
  output logic [N_CPU-1:0]        irq_req
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_SRC-1:0]  qual;
    logic [RANK_W-1:0] best_rank;
    logic [ID_W-1:0]   best_id;

    assign qual = src_en[c*N_SRC +: N_SRC] & src_pend[c*N_SRC +: N_SRC];

    hpsel_tree #(.N_SRC(N_SRC)) u_tree (
      .qual      (qual),
      .prio      (src_prio),
      .best_rank (best_rank),
      .best_id   (best_id)
    );

    hpsel_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_on    (dist_en & cpu_en[c]),
      .best_rank (best_rank),
      .best_id   (best_id),
      .mask      (prio_mask[c*PRIO_W +: PRIO_W]),
      .run       (run_prio[c*RANK_W +: RANK_W]),
      .pend_id   (pend_id[c*ID_W +: ID_W]),
      .irq       (irq_req[c])
    );
  end
endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk
  import hpsel_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dist_en,
  input logic [N_CPU-1:0]        cpu_en,
  input logic [N_CPU*N_SRC-1:0]  src_en,
  input logic [N_CPU*N_SRC-1:0]  src_pend,
  input logic [N_SRC*PRIO_W-1:0] src_prio,
  input logic [N_CPU*PRIO_W-1:0] prio_mask,
  input logic [N_CPU*RANK_W-1:0] run_prio,
  input logic [N_CPU*ID_W-1:0]   pend_id,
  input logic [N_CPU-1:0]        irq_req
);
  // Inputs as they stood at the last edge, matching the registered outputs.
  logic [N_CPU*N_SRC-1:0]  qual_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [N_CPU*PRIO_W-1:0] mask_q;
  logic [N_CPU*RANK_W-1:0] run_q;

  always_ff @(posedge clk) begin
    qual_q <= src_en & src_pend;
    prio_q <= src_prio;
    mask_q <= prio_mask;
    run_q  <= run_prio;
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_chk
    logic [ID_W-1:0]   pid;
    logic              pid_real;
    logic              win_qual;
    logic [RANK_W-1:0] win_rank;

    assign pid      = pend_id[c*ID_W +: ID_W];
    assign pid_real = int'(pid) < N_SRC;

    always_comb begin
      win_qual = 1'b0;
      win_rank = RANK_IDLE;
      if (pid_real) begin
        win_qual = qual_q[c*N_SRC + int'(pid)];
        win_rank = {1'b0, prio_q[int'(pid)*PRIO_W +: PRIO_W]};
      end
    end

    p_winner_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pid != ID_NONE) |-> win_qual);

    p_id_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pid == ID_NONE) || pid_real);

    p_under_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pid != ID_NONE) |-> (win_rank < {1'b0, mask_q[c*PRIO_W +: PRIO_W]}));

    p_under_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> ((pid != ID_NONE) && (win_rank < run_q[c*RANK_W +: RANK_W])));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dist_en || !cpu_en[c]) |=> ((pend_id[c*ID_W +: ID_W] == ID_NONE) && !irq_req[c]));

    p_reset_values_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((pid == ID_NONE) && !irq_req[c]));
  end
endmodule

bind hpsel_top hpsel_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dist_en   (dist_en),
  .cpu_en    (cpu_en),
  .src_en    (src_en),
  .src_pend  (src_pend),
  .src_prio  (src_prio),
  .prio_mask (prio_mask),
  .run_prio  (run_prio),
  .pend_id   (pend_id),
  .irq_req   (irq_req)
);

// File: tb/sim_hpsel_top.sv
`timescale 1ns/1ps
module sim_hpsel_top;
  localparam int NS = 5;
  localparam int NC = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dist_en;
  logic [NC-1:0]  cpu_en;
  logic [NC*NS-1:0] src_en, src_pend;
  logic [NS*8-1:0]  src_prio;
  logic [NC*8-1:0]  prio_mask;
  logic [NC*9-1:0]  run_prio;
  logic [NC*10-1:0] pend_id;
  logic [NC-1:0]    irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  hpsel_top #(.N_SRC(NS), .N_CPU(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .src_en(src_en), .src_pend(src_pend), .src_prio(src_prio),
    .prio_mask(prio_mask), .run_prio(run_prio),
    .pend_id(pend_id), .irq_req(irq_req)
  );

  typedef struct packed {
    logic [4:0]  en;
    logic [4:0]  pend;
    logic [39:0] prio;   // {p4,p3,p2,p1,p0}
    logic [7:0]  mask;
    logic [8:0]  run;
    logic [9:0]  id;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{5'b11111, 5'b00000, 40'h50_40_30_20_10, 8'hFF, 9'h100, 10'd1023, 1'b0},
    '{5'b11111, 5'b00100, 40'h50_50_40_50_50, 8'hFF, 9'h100, 10'd2,    1'b1},
    '{5'b11111, 5'b10110, 40'h10_99_30_30_00, 8'hFF, 9'h100, 10'd4,    1'b1},
    '{5'b11111, 5'b00110, 40'h10_99_30_30_00, 8'hFF, 9'h100, 10'd1,    1'b1},
    '{5'b11101, 5'b00110, 40'h00_00_50_10_00, 8'hFF, 9'h100, 10'd2,    1'b1},
    '{5'b11111, 5'b01000, 40'h00_80_00_00_00, 8'h80, 9'h100, 10'd1023, 1'b0},
    '{5'b11111, 5'b01000, 40'h00_80_00_00_00, 8'h81, 9'h080, 10'd3,    1'b0},
    '{5'b11111, 5'b01000, 40'h00_80_00_00_00, 8'h81, 9'h081, 10'd3,    1'b1},
    '{5'b11111, 5'b00001, 40'h00_00_00_00_FF, 8'hFF, 9'h100, 10'd1023, 1'b0},
    '{5'b11111, 5'b11111, 40'h00_00_00_00_00, 8'h01, 9'h000, 10'd0,    1'b0},
    '{5'b11111, 5'b11111, 40'h00_00_00_00_00, 8'h01, 9'h001, 10'd0,    1'b1},
    '{5'b11111, 5'b11000, 40'h20_21_00_00_00, 8'hFF, 9'h100, 10'd4,    1'b1}
  };

  function automatic string row_tag(input int r);
    case (r)
      0:       return "R3 empty";
      1:       return "R1 single";
      2, 3:    return "R1 tie";
      4:       return "R2 enable";
      5, 8:    return "R4 mask";
      6, 7:    return "R5 running";
      9, 10:   return "R5 top priority";
      default: return "R1 last id";
    endcase
  endfunction

  task automatic check(input string req, input int c,
                       input logic [9:0] exp_id, input logic exp_irq);
    logic [9:0] got_id;
    got_id = pend_id[c*10 +: 10];
    n_chk++;
    if (got_id !== exp_id || irq_req[c] !== exp_irq) begin
      n_fail++;
      $display("FAIL %s cpu%0d: id=%0d irq=%b, expected id=%0d irq=%b",
               req, c, got_id, irq_req[c], exp_id, exp_irq);
    end
  endtask

  task automatic set_cpu(input int c, input logic [4:0] en, input logic [4:0] pend,
                         input logic [7:0] mask, input logic [8:0] run);
    src_en[c*NS +: NS]   = en;
    src_pend[c*NS +: NS] = pend;
    prio_mask[c*8 +: 8]  = mask;
    run_prio[c*9 +: 9]   = run;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    dist_en  = 1'b1;
    cpu_en   = 2'b11;
    src_prio = 40'h00_00_40_00_00;
    set_cpu(0, 5'b11111, 5'b00100, 8'hFF, 9'h100);
    set_cpu(1, 5'b11111, 5'b00100, 8'hFF, 9'h100);
    repeat (3) @(negedge clk);
    // R8: a winner exists at the inputs but reset holds the outputs
    check("R8 reset", 0, 10'd1023, 1'b0);
    check("R8 reset", 1, 10'd1023, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first edge after reset", 0, 10'd2, 1'b1);

    // Table walk on CPU0, CPU1 kept empty
    for (int r = 0; r < NV; r++) begin
      src_prio = TBL[r].prio;
      set_cpu(0, TBL[r].en, TBL[r].pend, TBL[r].mask, TBL[r].run);
      set_cpu(1, 5'b11111, 5'b00000, 8'hFF, 9'h100);
      @(negedge clk);
      check(row_tag(r), 0, TBL[r].id, TBL[r].irq);
      check("R2 cpu1 nothing pending", 1, 10'd1023, 1'b0);
    end

    // R7: a change is not visible before the next rising edge
    src_prio = 40'h30_00_40_00_00;
    set_cpu(0, 5'b11111, 5'b00100, 8'hFF, 9'h100);
    @(negedge clk);
    check("R7 settle", 0, 10'd2, 1'b1);
    set_cpu(0, 5'b11111, 5'b10000, 8'hFF, 9'h100);
    #2;
    check("R7 holds before edge", 0, 10'd2, 1'b1);
    @(negedge clk);
    check("R7 after edge", 0, 10'd4, 1'b1);

    // R6: distributor enable low silences both CPUs
    set_cpu(1, 5'b11111, 5'b00100, 8'hFF, 9'h100);
    dist_en = 1'b0;
    @(negedge clk);
    check("R6 dist off", 0, 10'd1023, 1'b0);
    check("R6 dist off", 1, 10'd1023, 1'b0);
    dist_en = 1'b1;
    cpu_en  = 2'b01;
    @(negedge clk);
    check("R6 cpu1 off", 1, 10'd1023, 1'b0);
    check("R9 cpu0 unaffected", 0, 10'd4, 1'b1);
    cpu_en = 2'b11;

    // R9: different pending sets and thresholds per CPU
    src_prio = 40'h00_40_00_60_00;
    set_cpu(0, 5'b11111, 5'b01000, 8'hFF, 9'h100);
    set_cpu(1, 5'b11111, 5'b00010, 8'h50, 9'h100);
    @(negedge clk);
    check("R9 cpu0", 0, 10'd3, 1'b1);
    check("R9 cpu1 masked", 1, 10'd1023, 1'b0);
    set_cpu(1, 5'b11111, 5'b00010, 8'h61, 9'h060);
    @(negedge clk);
    check("R9 cpu1 shown", 1, 10'd1, 1'b0);
    check("R9 cpu0 still", 0, 10'd3, 1'b1);

    // R2: enable of CPU1 does not qualify CPU0's pending source
    set_cpu(0, 5'b00000, 5'b00010, 8'hFF, 9'h100);
    set_cpu(1, 5'b00010, 5'b00000, 8'hFF, 9'h100);
    @(negedge clk);
    check("R2 split en/pend", 0, 10'd1023, 1'b0);
    check("R2 split en/pend", 1, 10'd1023, 1'b0);

    // R8: reset in mid-run clears the outputs
    set_cpu(0, 5'b11111, 5'b01000, 8'hFF, 9'h100);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R8 async reset", 0, 10'd1023, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 recover", 0, 10'd3, 1'b1);

    done = 1;
    finish_run();
  end
endmodule